// File: doc/BRIEF.md
# Coherent Cache Miss-Status Entry

This block is one miss-status entry of a non-blocking coherent cache. It tracks a single outstanding block miss and the requests waiting on it. Waiting requests ("targets") are held in two ordered queues: a primary queue served by the response now in flight, and a deferred queue whose targets need a fresh request after that response. Each target carries a 3-bit command code, a 2-bit source tag, an order tag and a ready time.

The entry also keeps the coherence status of the miss: in service, pending dirty (an owned copy is on its way), post-invalidate and post-downgrade (a snoop will take the block away or make it shared once it arrives), forward, forward-without-response, uncacheable and downstream-pending. Snoops from the memory side are judged against that status in the same cycle. A snoop may queue a copy of itself as a target, rewrite upgrade commands that can no longer succeed, and tell the bus to inhibit memory, to supply an exclusive copy or to mark the line shared. A fill that returns an exclusive copy can merge the deferred targets back into the primary queue. Only one operation strobe may be active in a cycle. State changes on the rising clock edge; the snoop, refusal and free outputs are combinational.

Top module: `missEntry`

Command codes: 0 read, 1 read-exclusive, 2 upgrade, 3 conditional-store upgrade, 4 conditional store, 5 conditional-store-upgrade fail, 6 conditional-store fail, 7 hardware prefetch. Codes 1 to 6 need exclusive ownership. Codes 2, 3 and 4 count as upgrades. Source tags: 0 CPU, 1 snoop, 2 prefetcher.

## Requirements
- R1: Allocation empties both queues and stores its command as the only primary target. The target's source is 2 when the command is 7 and 0 otherwise. Allocation loads the entry order and ready time, takes the forward, no-response and uncacheable flags from its inputs, and clears in service, pending dirty, both post flags, downstream-pending and the error flag.
- R2: A target that does not come from a snoop sets its queue's needs-exclusive flag when its code is 1 to 6, and sets its queue's has-upgrade flag when its code is 2, 3 or 4. A queue rewrite changes 2 to 1, 3 to 5 and 4 to 6 on every stored target. The rewrite acts only while has-upgrade is set, and it clears has-upgrade.
- R3: A CPU add goes to the deferred queue only while the entry is in service and one of these holds: the deferred queue is non-empty; post-invalidate is set; or the command needs exclusive ownership while pending dirty is clear, post-downgrade is set or forward is set. A target deferred while post-invalidate is set is stored with its upgrade code rewritten. Every other add is appended to the primary queue with source 0.
- R4: An add whose selected queue already holds DEPTH targets raises addRefused in the same cycle and changes no queue.
- R5: An add with command 7, or any add to an uncacheable entry, stores nothing and sets errFlag. errFlag stays set until the next allocation.
- R6: Mark-in-service on an entry without forward-no-response sets in service, sets pending dirty to the primary needs-exclusive flag OR svcDirtyResp, and clears both post flags.
- R7: Mark-in-service on an entry allocated with forward and no-response raises svcFree in the same cycle and pops the primary target. In service stays clear.
- R8: A snoop has no effect while the entry is not in service, or while it is express and downstream-pending is set. In that case handled, inhibit, supply-exclusive and shared are all low, and an exclusive snoop rewrites upgrades in both queues.
- R9: Any other snoop is handled. An exclusive snoop rewrites the deferred queue. If post-invalidate was already set, nothing else happens. Otherwise, when pending dirty is set or the snoop invalidates, a copy of the snoop (source 1, ready time nowTime) is appended to the primary queue if there is room. Inhibit and supply-exclusive follow pending dirty, and an exclusive snoop sets post-invalidate.
- R10: A handled snoop that is neither exclusive nor uncacheable, with post-invalidate clear, sets post-downgrade and raises snpShared.
- R11: Promotion with an empty primary queue and a non-empty deferred queue moves the deferred targets and flags into the primary queue and leaves the deferred queue empty with clear flags. The entry order becomes the new head's order, and the entry ready time becomes the larger of nowTime and the head's ready time. In any other case promotion does nothing.
- R12: A fill without the shared flag, arriving while both post flags are clear and the deferred needs-exclusive flag is set, appends all deferred targets behind the primary ones in order. It sets primary needs-exclusive and empties the deferred queue. Any other fill changes nothing.
- R13: After reset, and after a deallocation with an empty primary queue, in service and all queue flags are clear. A deallocation with a non-empty primary queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| allocValid | input | 1 | Allocate the entry |
| allocCmd | input | 3 | Command of the first target |
| allocOrder | input | ORD_W | Order tag of the first target |
| allocReady | input | TIME_W | Ready time of the first target |
| allocUncache | input | 1 | Entry is uncacheable |
| allocForward | input | 1 | Entry forwards its request |
| allocNoResp | input | 1 | Forwarded request expects no response |
| addValid | input | 1 | Add a CPU target |
| addCmd | input | 3 | Command of the added target |
| addOrder | input | ORD_W | Order tag of the added target |
| addReady | input | TIME_W | Ready time of the added target |
| addRefused | output | 1 | Selected queue is full |
| svcValid | input | 1 | Mark the entry in service |
| svcDirtyResp | input | 1 | Response will arrive dirty |
| svcFree | output | 1 | Mark-in-service freed the entry |
| snpValid | input | 1 | Snoop present |
| snpCmd | input | 3 | Snoop command code |
| snpOrder | input | ORD_W | Snoop order tag |
| snpExcl | input | 1 | Snoop needs exclusive ownership |
| snpInval | input | 1 | Snoop invalidates |
| snpExpress | input | 1 | Snoop is express |
| snpUncache | input | 1 | Snoop is uncacheable |
| snpHandled | output | 1 | Snoop is handled by this entry |
| snpInhibit | output | 1 | Inhibit memory response |
| snpSupplyExcl | output | 1 | Supply an exclusive copy |
| snpShared | output | 1 | Mark response shared |
| fillValid | input | 1 | Fill arrived |
| fillShared | input | 1 | Fill carries the shared flag |
| popValid | input | 1 | Pop primary head |
| promoteValid | input | 1 | Promote the deferred queue |
| deallocValid | input | 1 | Deallocate the entry |
| dnPendSet | input | 1 | Set downstream-pending |
| dnPendClr | input | 1 | Clear downstream-pending |
| nowTime | input | TIME_W | Current time |
| headCmd | output | 3 | Primary head command |
| headSrc | output | 2 | Primary head source |
| headOrder | output | ORD_W | Primary head order |
| headReady | output | TIME_W | Primary head ready time |
| primCount | output | CW | Primary target count |
| defCount | output | CW | Deferred target count |
| primFull | output | 1 | Primary queue full |
| primEmpty | output | 1 | Primary queue empty |
| defFull | output | 1 | Deferred queue full |
| defEmpty | output | 1 | Deferred queue empty |
| inService | output | 1 | In service flag |
| pendingDirty | output | 1 | Pending dirty flag |
| postInvalid | output | 1 | Post-invalidate flag |
| postDowngrade | output | 1 | Post-downgrade flag |
| downPending | output | 1 | Downstream-pending flag |
| entryOrder | output | ORD_W | Entry order tag |
| entryReady | output | TIME_W | Entry ready time |
| errFlag | output | 1 | Illegal add seen since allocation |

## Verification
The hardest state to reach is an in-service entry that holds queued upgrades, snoop copies and deferred targets all at once. Only there do the rewrite, post-invalidate and merge rules interact. The stimulus builds it in steps. It allocates with an upgrade, adds further upgrades and exclusive requests so the has-upgrade and needs-exclusive flags are set, marks the entry in service with and without a dirty response, and then sends exclusive, invalidating, express and shared snoops in turn. Adds that follow land in the deferred queue already rewritten. The targets are then popped one by one and promoted or merged, which makes every stored command, order tag and source visible at the head outputs.

// File: rtl/missPkg.sv
package missPkg;
  localparam int ORD_W  = 8;
  localparam int TIME_W = 16;

  typedef enum logic [2:0] {
    CMD_READ        = 3'd0,
    CMD_READ_EX     = 3'd1,
    CMD_UPGRADE     = 3'd2,
    CMD_SC_UPGRADE  = 3'd3,
    CMD_STORE_COND  = 3'd4,
    CMD_SC_UPG_FAIL = 3'd5,
    CMD_SC_FAIL     = 3'd6,
    CMD_PREFETCH    = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    SRC_CPU   = 2'd0,
    SRC_SNOOP = 2'd1,
    SRC_PREF  = 2'd2
  } src_e;

  typedef struct packed {
    cmd_e              cmd;
    src_e              src;
    logic [ORD_W-1:0]  ord;
    logic [TIME_W-1:0] rdy;
  } tgt_t;

  // strobes from control to the queue datapath
  typedef struct packed {
    logic initPrim;
    logic pushPrim;
    logic pushDef;
    logic countFlags;
    logic rewPrim;
    logic rewDef;
    logic popPrim;
    logic promote;
    logic merge;
    logic clrFlags;
    tgt_t entry;
  } qOps_t;

  function automatic logic needsExcl(cmd_e c);
    return (c != CMD_READ) && (c != CMD_PREFETCH);
  endfunction

  function automatic logic isUpgCmd(cmd_e c);
    return (c == CMD_UPGRADE) || (c == CMD_SC_UPGRADE) || (c == CMD_STORE_COND);
  endfunction

  function automatic cmd_e upgRewrite(cmd_e c);
    case (c)
      CMD_UPGRADE:    return CMD_READ_EX;
      CMD_SC_UPGRADE: return CMD_SC_UPG_FAIL;
      CMD_STORE_COND: return CMD_SC_FAIL;
      default:        return c;
    endcase
  endfunction
endpackage

// File: rtl/missQueues.sv
module missQueues
  import missPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  qOps_t         ops,
  output tgt_t          primHead,
  output tgt_t          defHead,
  output logic [CW-1:0] pCnt,
  output logic [CW-1:0] dCnt,
  output logic          pNeedEx,
  output logic          dNeedEx
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  tgt_t primQ [DEPTH];
  tgt_t defQ  [DEPTH];
  tgt_t pN [DEPTH];
  tgt_t dN [DEPTH];
  logic [CW-1:0] pc, dc;
  logic pUpg, dUpg, pe, pu, de, du;
  int sum;

  always_comb begin
    pN = primQ; dN = defQ; pc = pCnt; dc = dCnt;
    pe = pNeedEx; pu = pUpg; de = dNeedEx; du = dUpg;
    sum = 0;
    if (ops.rewPrim && pUpg) begin
      for (int i = 0; i < DEPTH; i++) pN[i].cmd = upgRewrite(pN[i].cmd);
      pu = 1'b0;
    end
    if (ops.rewDef && dUpg) begin
      for (int i = 0; i < DEPTH; i++) dN[i].cmd = upgRewrite(dN[i].cmd);
      du = 1'b0;
    end
    if (ops.initPrim) begin
      pc = '0; dc = '0; pe = 1'b0; pu = 1'b0; de = 1'b0; du = 1'b0;
    end
    if (ops.popPrim && pc != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) pN[i] = pN[i+1];
      pc = pc - CW'(1);
    end
    if (ops.pushPrim && pc < FULLV) begin
      pN[pc[IW-1:0]] = ops.entry;
      pc = pc + CW'(1);
      if (ops.countFlags) begin
        pe = pe | needsExcl(ops.entry.cmd);
        pu = pu | isUpgCmd(ops.entry.cmd);
      end
    end
    if (ops.pushDef && dc < FULLV) begin
      dN[dc[IW-1:0]] = ops.entry;
      dc = dc + CW'(1);
      if (ops.countFlags) begin
        de = de | needsExcl(ops.entry.cmd);
        du = du | isUpgCmd(ops.entry.cmd);
      end
    end
    if (ops.merge) begin
      sum = int'(pc) + int'(dc);
      for (int i = 0; i < DEPTH; i++)
        if (i >= int'(pc) && i < sum) pN[i] = dN[IW'(i - int'(pc))];
      pc = (sum > DEPTH) ? FULLV : CW'(sum);
      pe = 1'b1; pu = pu | du;
      dc = '0; de = 1'b0; du = 1'b0;
    end
    if (ops.promote) begin
      pN = dN; pc = dc; pe = de; pu = du;
      dc = '0; de = 1'b0; du = 1'b0;
    end
    if (ops.clrFlags) begin
      pe = 1'b0; pu = 1'b0; de = 1'b0; du = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        primQ[i] <= '0;
        defQ[i]  <= '0;
      end
      pCnt <= '0; dCnt <= '0;
      pNeedEx <= 1'b0; pUpg <= 1'b0; dNeedEx <= 1'b0; dUpg <= 1'b0;
    end else begin
      primQ <= pN; defQ <= dN;
      pCnt <= pc; dCnt <= dc;
      pNeedEx <= pe; pUpg <= pu; dNeedEx <= de; dUpg <= du;
    end
  end

  assign primHead = primQ[0];
  assign defHead  = defQ[0];
endmodule

// File: rtl/missCtrl.sv
module missCtrl
  import missPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [2:0]        allocCmd,
  input  logic [ORD_W-1:0]  allocOrder,
  input  logic [TIME_W-1:0] allocReady,
  input  logic              allocUncache,
  input  logic              allocForward,
  input  logic              allocNoResp,
  input  logic              addValid,
  input  logic [2:0]        addCmd,
  input  logic [ORD_W-1:0]  addOrder,
  input  logic [TIME_W-1:0] addReady,
  input  logic              svcValid,
  input  logic              svcDirtyResp,
  input  logic              snpValid,
  input  logic [2:0]        snpCmd,
  input  logic [ORD_W-1:0]  snpOrder,
  input  logic              snpExcl,
  input  logic              snpInval,
  input  logic              snpExpress,
  input  logic              snpUncache,
  input  logic              fillValid,
  input  logic              fillShared,
  input  logic              popValid,
  input  logic              promoteValid,
  input  logic              deallocValid,
  input  logic              dnPendSet,
  input  logic              dnPendClr,
  input  logic [TIME_W-1:0] nowTime,
  input  logic [CW-1:0]     pCnt,
  input  logic [CW-1:0]     dCnt,
  input  logic              pNeedEx,
  input  logic              dNeedEx,
  input  tgt_t              defHead,
  output qOps_t             ops,
  output logic              addRefused,
  output logic              svcFree,
  output logic              snpHandled,
  output logic              snpInhibit,
  output logic              snpSupplyExcl,
  output logic              snpShared,
  output logic              inService,
  output logic              pendingDirty,
  output logic              postInvalid,
  output logic              postDowngrade,
  output logic              downPending,
  output logic [ORD_W-1:0]  entryOrder,
  output logic [TIME_W-1:0] entryReady,
  output logic              errFlag
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  logic fwd, noResp, uncache;
  logic svcN, pdN, piN, pgN, fwdN, nrN, uncN, dnN, errN;
  logic [ORD_W-1:0]  ordN;
  logic [TIME_W-1:0] rdyN;
  logic snpNoEff, addDefer, addBad, addFull, fillMerge;
  cmd_e aCmd;

  assign aCmd     = cmd_e'(addCmd);
  assign snpNoEff = !inService || (snpExpress && downPending);
  assign addDefer = inService && ((dCnt != '0) || postInvalid ||
                    (needsExcl(aCmd) && (!pendingDirty || postDowngrade || fwd)));
  assign addBad   = (aCmd == CMD_PREFETCH) || uncache;
  assign addFull  = addDefer ? (dCnt == FULLV) : (pCnt == FULLV);
  assign fillMerge = !fillShared && !postInvalid && !postDowngrade && dNeedEx;

  assign addRefused    = addValid && addFull;
  assign svcFree       = svcValid && fwd && noResp;
  assign snpHandled    = snpValid && !snpNoEff;
  assign snpInhibit    = snpHandled && !postInvalid && pendingDirty;
  assign snpSupplyExcl = snpHandled && !postInvalid && pendingDirty;
  assign snpShared     = snpHandled && !postInvalid && !snpExcl && !snpUncache;

  always_comb begin
    ops = '0;
    svcN = inService; pdN = pendingDirty; piN = postInvalid; pgN = postDowngrade;
    fwdN = fwd; nrN = noResp; uncN = uncache; errN = errFlag;
    ordN = entryOrder; rdyN = entryReady;
    dnN = downPending;
    if (dnPendSet) dnN = 1'b1;
    if (dnPendClr) dnN = 1'b0;
    if (allocValid) begin
      ops.initPrim = 1'b1; ops.pushPrim = 1'b1; ops.countFlags = 1'b1;
      ops.entry.cmd = cmd_e'(allocCmd);
      ops.entry.src = (cmd_e'(allocCmd) == CMD_PREFETCH) ? SRC_PREF : SRC_CPU;
      ops.entry.ord = allocOrder;
      ops.entry.rdy = allocReady;
      svcN = 1'b0; pdN = 1'b0; piN = 1'b0; pgN = 1'b0; dnN = 1'b0; errN = 1'b0;
      fwdN = allocForward; nrN = allocNoResp; uncN = allocUncache;
      ordN = allocOrder; rdyN = allocReady;
    end else if (svcValid) begin
      if (fwd && noResp) begin
        ops.popPrim = 1'b1;
      end else begin
        svcN = 1'b1;
        pdN = pNeedEx || svcDirtyResp;
        piN = 1'b0; pgN = 1'b0;
      end
    end else if (snpValid) begin
      if (snpNoEff) begin
        ops.rewPrim = snpExcl;
        ops.rewDef  = snpExcl;
      end else begin
        ops.rewDef = snpExcl;
        if (!postInvalid) begin
          if (pendingDirty || snpInval) begin
            ops.pushPrim  = 1'b1;
            ops.entry.cmd = cmd_e'(snpCmd);
            ops.entry.src = SRC_SNOOP;
            ops.entry.ord = snpOrder;
            ops.entry.rdy = nowTime;
            if (snpExcl) piN = 1'b1;
          end
          if (!snpExcl && !snpUncache) pgN = 1'b1;
        end
      end
    end else if (fillValid) begin
      ops.merge = fillMerge;
    end else if (addValid) begin
      if (addBad) begin
        errN = 1'b1;
      end else if (!addFull) begin
        ops.pushDef    = addDefer;
        ops.pushPrim   = !addDefer;
        ops.countFlags = 1'b1;
        ops.entry.cmd  = (addDefer && postInvalid) ? upgRewrite(aCmd) : aCmd;
        ops.entry.src  = SRC_CPU;
        ops.entry.ord  = addOrder;
        ops.entry.rdy  = addReady;
      end
    end else if (popValid) begin
      ops.popPrim = 1'b1;
    end else if (promoteValid) begin
      if (pCnt == '0 && dCnt != '0) begin
        ops.promote = 1'b1;
        ordN = defHead.ord;
        rdyN = (nowTime > defHead.rdy) ? nowTime : defHead.rdy;
      end
    end else if (deallocValid) begin
      if (pCnt == '0) begin
        ops.clrFlags = 1'b1;
        svcN = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inService <= 1'b0; pendingDirty <= 1'b0; postInvalid <= 1'b0;
      postDowngrade <= 1'b0; downPending <= 1'b0; errFlag <= 1'b0;
      fwd <= 1'b0; noResp <= 1'b0; uncache <= 1'b0;
      entryOrder <= '0; entryReady <= '0;
    end else begin
      inService <= svcN; pendingDirty <= pdN; postInvalid <= piN;
      postDowngrade <= pgN; downPending <= dnN; errFlag <= errN;
      fwd <= fwdN; noResp <= nrN; uncache <= uncN;
      entryOrder <= ordN; entryReady <= rdyN;
    end
  end
endmodule

// File: rtl/missEntry.sv
module missEntry
  import missPkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              allocValid,
  input  logic [2:0]        allocCmd,
  input  logic [ORD_W-1:0]  allocOrder,
  input  logic [TIME_W-1:0] allocReady,
  input  logic              allocUncache,
  input  logic              allocForward,
  input  logic              allocNoResp,
  input  logic              addValid,
  input  logic [2:0]        addCmd,
  input  logic [ORD_W-1:0]  addOrder,
  input  logic [TIME_W-1:0] addReady,
  output logic              addRefused,
  input  logic              svcValid,
  input  logic              svcDirtyResp,
  output logic              svcFree,
  input  logic              snpValid,
  input  logic [2:0]        snpCmd,
  input  logic [ORD_W-1:0]  snpOrder,
  input  logic              snpExcl,
  input  logic              snpInval,
  input  logic              snpExpress,
  input  logic              snpUncache,
  output logic              snpHandled,
  output logic              snpInhibit,
  output logic              snpSupplyExcl,
  output logic              snpShared,
  input  logic              fillValid,
  input  logic              fillShared,
  input  logic              popValid,
  input  logic              promoteValid,
  input  logic              deallocValid,
  input  logic              dnPendSet,
  input  logic              dnPendClr,
  input  logic [TIME_W-1:0] nowTime,
  output logic [2:0]        headCmd,
  output logic [1:0]        headSrc,
  output logic [ORD_W-1:0]  headOrder,
  output logic [TIME_W-1:0] headReady,
  output logic [CW-1:0]     primCount,
  output logic [CW-1:0]     defCount,
  output logic              primFull,
  output logic              primEmpty,
  output logic              defFull,
  output logic              defEmpty,
  output logic              inService,
  output logic              pendingDirty,
  output logic              postInvalid,
  output logic              postDowngrade,
  output logic              downPending,
  output logic [ORD_W-1:0]  entryOrder,
  output logic [TIME_W-1:0] entryReady,
  output logic              errFlag
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  qOps_t ops;
  tgt_t  primHead, defHead;
  logic  pNeedEx, dNeedEx;

  missCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk, .rstN,
    .allocValid, .allocCmd, .allocOrder, .allocReady, .allocUncache, .allocForward, .allocNoResp,
    .addValid, .addCmd, .addOrder, .addReady,
    .svcValid, .svcDirtyResp,
    .snpValid, .snpCmd, .snpOrder, .snpExcl, .snpInval, .snpExpress, .snpUncache,
    .fillValid, .fillShared, .popValid, .promoteValid, .deallocValid,
    .dnPendSet, .dnPendClr, .nowTime,
    .pCnt(primCount), .dCnt(defCount), .pNeedEx, .dNeedEx, .defHead,
    .ops, .addRefused, .svcFree,
    .snpHandled, .snpInhibit, .snpSupplyExcl, .snpShared,
    .inService, .pendingDirty, .postInvalid, .postDowngrade, .downPending,
    .entryOrder, .entryReady, .errFlag
  );

  missQueues #(.DEPTH(DEPTH)) uQueues (
    .clk, .rstN, .ops,
    .primHead, .defHead,
    .pCnt(primCount), .dCnt(defCount),
    .pNeedEx, .dNeedEx
  );

  assign headCmd   = primHead.cmd;
  assign headSrc   = primHead.src;
  assign headOrder = primHead.ord;
  assign headReady = primHead.rdy;
  assign primFull  = (primCount == FULLV);
  assign primEmpty = (primCount == '0);
  assign defFull   = (defCount == FULLV);
  assign defEmpty  = (defCount == '0);
endmodule

// File: rtl/missCheck.sv
module missCheck #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          allocValid,
  input logic          addValid,
  input logic          addRefused,
  input logic          svcValid,
  input logic          svcFree,
  input logic          snpValid,
  input logic          snpHandled,
  input logic          snpInhibit,
  input logic          snpShared,
  input logic          fillValid,
  input logic          fillShared,
  input logic          popValid,
  input logic          promoteValid,
  input logic          deallocValid,
  input logic [CW-1:0] primCount,
  input logic [CW-1:0] defCount,
  input logic          primEmpty,
  input logic          defEmpty,
  input logic          inService,
  input logic          postInvalid,
  input logic          postDowngrade,
  input logic          downPending
);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);

  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rstN)
    $countones({allocValid, addValid, svcValid, snpValid, fillValid,
                popValid, promoteValid, deallocValid}) <= 1); // R13
  AST_ALLOC_INIT: assert property (@(posedge clk) disable iff (!rstN)
    allocValid |=> !inService && !downPending && defEmpty && primCount == CW'(1)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    primCount <= FULLV && defCount <= FULLV); // R4
  AST_REFUSE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    addRefused |=> $stable(primCount) && $stable(defCount)); // R4
  AST_SVC_SET: assert property (@(posedge clk) disable iff (!rstN)
    svcValid && !svcFree |=> inService && !postInvalid && !postDowngrade); // R6
  AST_FWD_FREE: assert property (@(posedge clk) disable iff (!rstN)
    svcFree |=> primEmpty && !inService); // R7
  AST_SNP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    snpValid && !inService |-> !snpHandled && !snpInhibit && !snpShared); // R8
  AST_POSTINV_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    snpHandled && postInvalid |-> !snpInhibit && !snpShared); // R9
  AST_PROMOTE_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    promoteValid && primEmpty && !defEmpty |=> defEmpty && !primEmpty); // R11
  AST_SHARED_FILL: assert property (@(posedge clk) disable iff (!rstN)
    fillValid && fillShared |=> $stable(defCount) && $stable(primCount)); // R12
  AST_DEALLOC_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    deallocValid && primEmpty |=> !inService); // R13
endmodule

bind missEntry missCheck #(.DEPTH(DEPTH)) uChk (.*);

// File: tb/sim_missEntry.sv
module sim_missEntry;
  import missPkg::*;
  localparam int PER = 10;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rstN = 1'b0;
  logic allocValid = 0, allocUncache = 0, allocForward = 0, allocNoResp = 0;
  logic [2:0] allocCmd = 0, addCmd = 0, snpCmd = 0;
  logic [ORD_W-1:0] allocOrder = 0, addOrder = 0, snpOrder = 0;
  logic [TIME_W-1:0] allocReady = 0, addReady = 0, nowTime = 0;
  logic addValid = 0, svcValid = 0, svcDirtyResp = 0;
  logic snpValid = 0, snpExcl = 0, snpInval = 0, snpExpress = 0, snpUncache = 0;
  logic fillValid = 0, fillShared = 0, popValid = 0, promoteValid = 0, deallocValid = 0;
  logic dnPendSet = 0, dnPendClr = 0;
  logic addRefused, svcFree, snpHandled, snpInhibit, snpSupplyExcl, snpShared;
  logic [2:0] headCmd; logic [1:0] headSrc;
  logic [ORD_W-1:0] headOrder, entryOrder;
  logic [TIME_W-1:0] headReady, entryReady;
  logic [CW-1:0] primCount, defCount;
  logic primFull, primEmpty, defFull, defEmpty;
  logic inService, pendingDirty, postInvalid, postDowngrade, downPending, errFlag;

  missEntry #(.DEPTH(DEPTH)) u0 (.*);

  always #(PER/2) clk = ~clk;

  typedef struct { int cmd; int src; int ord; int rdy; } mt;
  mt mp[$], md[$];
  bit mSvc, mPD, mPI, mPG, mFwd, mNR, mUnc, mDn, mErr, pEx, pUp, dEx, dUp;
  int mOrd, mRdy;
  int nChk = 0, nErr = 0;
  string curReq = "R13";

  function automatic bit nEx(int c); return c >= 1 && c <= 6; endfunction
  function automatic bit isUp(int c); return c == 2 || c == 3 || c == 4; endfunction
  function automatic int rw(int c);
    return (c == 2) ? 1 : (c == 3) ? 5 : (c == 4) ? 6 : c;
  endfunction

  task automatic chk(string what, int act, int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  function automatic bit mDefer(int c);
    return mSvc && (md.size() != 0 || mPI || (nEx(c) && (!mPD || mPG || mFwd)));
  endfunction

  task automatic checkAll();
    bit noEff, h, defer;
    noEff = !mSvc || (snpExpress && mDn);
    h = snpValid && !noEff;
    defer = mDefer(int'(addCmd));
    chk("primCount", int'(primCount), mp.size());
    chk("defCount", int'(defCount), md.size());
    chk("primEmpty", int'(primEmpty), int'(mp.size() == 0));
    chk("primFull", int'(primFull), int'(mp.size() == DEPTH));
    chk("defEmpty", int'(defEmpty), int'(md.size() == 0));
    chk("defFull", int'(defFull), int'(md.size() == DEPTH));
    if (mp.size() != 0) begin
      chk("headCmd", int'(headCmd), mp[0].cmd);
      chk("headSrc", int'(headSrc), mp[0].src);
      chk("headOrder", int'(headOrder), mp[0].ord);
      chk("headReady", int'(headReady), mp[0].rdy);
    end
    chk("inService", int'(inService), int'(mSvc));
    chk("pendingDirty", int'(pendingDirty), int'(mPD));
    chk("postInvalid", int'(postInvalid), int'(mPI));
    chk("postDowngrade", int'(postDowngrade), int'(mPG));
    chk("downPending", int'(downPending), int'(mDn));
    chk("errFlag", int'(errFlag), int'(mErr));
    chk("entryOrder", int'(entryOrder), mOrd);
    chk("entryReady", int'(entryReady), mRdy);
    chk("addRefused", int'(addRefused),
        int'(addValid && (defer ? md.size() == DEPTH : mp.size() == DEPTH)));
    chk("svcFree", int'(svcFree), int'(svcValid && mFwd && mNR));
    chk("snpHandled", int'(snpHandled), int'(h));
    chk("snpInhibit", int'(snpInhibit), int'(h && !mPI && mPD));
    chk("snpSupplyExcl", int'(snpSupplyExcl), int'(h && !mPI && mPD));
    chk("snpShared", int'(snpShared), int'(h && !mPI && !snpExcl && !snpUncache));
  endtask

  task automatic rwq(ref mt q[$], ref bit up);
    if (up) begin
      foreach (q[i]) q[i].cmd = rw(q[i].cmd);
      up = 0;
    end
  endtask

  task automatic modelStep();
    mt t;
    if (dnPendSet) mDn = 1;
    if (dnPendClr) mDn = 0;
    if (allocValid) begin
      mp.delete(); md.delete();
      pEx = nEx(int'(allocCmd)); pUp = isUp(int'(allocCmd)); dEx = 0; dUp = 0;
      t = '{int'(allocCmd), (allocCmd == 3'd7) ? 2 : 0, int'(allocOrder), int'(allocReady)};
      mp.push_back(t);
      mSvc = 0; mPD = 0; mPI = 0; mPG = 0; mDn = 0; mErr = 0;
      mFwd = allocForward; mNR = allocNoResp; mUnc = allocUncache;
      mOrd = int'(allocOrder); mRdy = int'(allocReady);
    end else if (svcValid) begin
      if (mFwd && mNR) begin
        if (mp.size() != 0) void'(mp.pop_front());
      end else begin
        mSvc = 1; mPD = pEx || svcDirtyResp; mPI = 0; mPG = 0;
      end
    end else if (snpValid) begin
      if (!mSvc || (snpExpress && mDn)) begin
        if (snpExcl) begin rwq(mp, pUp); rwq(md, dUp); end
      end else begin
        if (snpExcl) rwq(md, dUp);
        if (!mPI) begin
          if (mPD || snpInval) begin
            t = '{int'(snpCmd), 1, int'(snpOrder), int'(nowTime)};
            if (mp.size() < DEPTH) mp.push_back(t);
            if (snpExcl) mPI = 1;
          end
          if (!snpExcl && !snpUncache) mPG = 1;
        end
      end
    end else if (fillValid) begin
      if (!fillShared && !mPI && !mPG && dEx) begin
        foreach (md[i]) if (mp.size() < DEPTH) mp.push_back(md[i]);
        md.delete(); pEx = 1; pUp = pUp | dUp; dEx = 0; dUp = 0;
      end
    end else if (addValid) begin
      if (addCmd == 3'd7 || mUnc) mErr = 1;
      else begin
        bit defer;
        int c;
        defer = mDefer(int'(addCmd));
        c = (defer && mPI) ? rw(int'(addCmd)) : int'(addCmd);
        t = '{c, 0, int'(addOrder), int'(addReady)};
        if (defer && md.size() < DEPTH) begin
          md.push_back(t); dEx |= nEx(c); dUp |= isUp(c);
        end else if (!defer && mp.size() < DEPTH) begin
          mp.push_back(t); pEx |= nEx(c); pUp |= isUp(c);
        end
      end
    end else if (popValid) begin
      if (mp.size() != 0) void'(mp.pop_front());
    end else if (promoteValid) begin
      if (mp.size() == 0 && md.size() != 0) begin
        mp = md; md.delete();
        pEx = dEx; pUp = dUp; dEx = 0; dUp = 0;
        mOrd = mp[0].ord;
        mRdy = (int'(nowTime) > mp[0].rdy) ? int'(nowTime) : mp[0].rdy;
      end
    end else if (deallocValid) begin
      if (mp.size() == 0) begin
        mSvc = 0; pEx = 0; pUp = 0; dEx = 0; dUp = 0;
      end
    end
  endtask

  task automatic tick();
    #(PER/4);
    checkAll();
    @(posedge clk); #1;
    modelStep();
    @(negedge clk);
  endtask

  task automatic clr();
    allocValid = 0; addValid = 0; svcValid = 0; snpValid = 0; fillValid = 0;
    popValid = 0; promoteValid = 0; deallocValid = 0; dnPendSet = 0; dnPendClr = 0;
  endtask

  task automatic doAlloc(int c, int o, int r, bit u, bit f, bit n);
    allocValid = 1; allocCmd = 3'(c); allocOrder = ORD_W'(o); allocReady = TIME_W'(r);
    allocUncache = u; allocForward = f; allocNoResp = n; tick(); clr();
  endtask
  task automatic doAdd(int c, int o, int r);
    addValid = 1; addCmd = 3'(c); addOrder = ORD_W'(o); addReady = TIME_W'(r); tick(); clr();
  endtask
  task automatic doSvc(bit d);
    svcValid = 1; svcDirtyResp = d; tick(); clr();
  endtask
  task automatic doSnp(int c, int o, bit ex, bit inv, bit expr, bit unc);
    snpValid = 1; snpCmd = 3'(c); snpOrder = ORD_W'(o); snpExcl = ex; snpInval = inv;
    snpExpress = expr; snpUncache = unc; tick(); clr();
  endtask
  task automatic doFill(bit sh);
    fillValid = 1; fillShared = sh; tick(); clr();
  endtask
  task automatic doPop(int n);
    for (int i = 0; i < n; i++) begin popValid = 1; tick(); clr(); end
  endtask
  task automatic doPromote(int now);
    promoteValid = 1; nowTime = TIME_W'(now); tick(); clr();
  endtask
  task automatic doDealloc();
    deallocValid = 1; tick(); clr();
  endtask

  initial begin
    #(PER * 100000);
    nErr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R13"; tick(); tick();
    // R1: prefetch allocation, then CPU allocation
    curReq = "R1"; doAlloc(7, 5, 100, 0, 0, 0); tick(); doPop(1);
    doAlloc(0, 6, 10, 0, 0, 0);
    // R2 / R3: adds before service go to primary
    curReq = "R2"; doAdd(1, 7, 11); doAdd(2, 8, 12);
    curReq = "R6"; doSvc(0);
    curReq = "R3"; doAdd(0, 9, 13); doAdd(1, 10, 14); doAdd(0, 11, 15); doAdd(0, 12, 16); doAdd(0, 13, 17);
    curReq = "R4"; doAdd(0, 14, 18); doAdd(1, 15, 19);
    curReq = "R5"; doAdd(7, 16, 20);
    // R9: exclusive invalidating snoop with pending dirty
    curReq = "R9"; doPop(2); doSnp(1, 30, 1, 1, 0, 0); doSnp(0, 31, 0, 0, 0, 0);
    curReq = "R3"; doAdd(2, 17, 50); doAdd(0, 18, 40);
    curReq = "R11"; doPop(8); doPromote(500); doPop(1);
    curReq = "R13"; doDealloc(); doPop(2); doDealloc();
    // R8: snoops with no effect
    curReq = "R8"; doAlloc(2, 1, 20, 0, 0, 0); doAdd(4, 2, 21);
    doSnp(1, 40, 1, 0, 0, 0); doPop(1);
    doAdd(3, 3, 22); dnPendSet = 1; tick(); clr();
    curReq = "R6"; doSvc(0);
    curReq = "R8"; doSnp(1, 41, 1, 1, 1, 0);
    dnPendClr = 1; tick(); clr();
    curReq = "R10"; nowTime = 77; doSnp(0, 42, 0, 0, 0, 0); doSnp(0, 43, 0, 0, 0, 1);
    doSnp(0, 44, 0, 0, 1, 0);
    // R12: exclusive fill merges the deferred queue
    curReq = "R12"; doPop(8); doDealloc();
    doAlloc(0, 2, 5, 0, 0, 0); doSvc(0); doAdd(1, 3, 6); doAdd(3, 4, 7);
    doFill(1); doFill(0); doPop(1); doPop(1); doPop(1);
    // R11: ready time taken from a later head
    curReq = "R11"; doDealloc(); doAlloc(0, 9, 5, 0, 0, 0); doSvc(0); doAdd(1, 12, 900);
    doPromote(100); doPop(1); doPromote(100); doPop(1);
    // R7: forward without response
    curReq = "R7"; doDealloc(); doAlloc(0, 20, 30, 0, 1, 1); doSvc(0); tick();
    // R5 / R6: uncacheable entry and dirty response
    curReq = "R5"; doAlloc(0, 21, 31, 1, 0, 0); doAdd(0, 22, 32);
    curReq = "R6"; doSvc(1); tick();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule